// File: doc/BRIEF.md
# Brown-out and Reset Delay Sequencer

This block merges two reset causes, a sustained supply dip and a watchdog expiry, into a single system reset. It then holds that reset for a fixed start-up delay before letting the rest of the chip run. The supply is seen only through two digital comparator flags. One says the supply is under the lower trip level and the other says it is over the upper trip level; hysteresis between them is handled outside. A glitch filter makes sure that only a dip lasting a minimum number of clock cycles counts as a brown-out. Shorter dips leave the chip running.

A qualified brown-out asserts reset at once. Reset stays asserted until the supply is seen above the upper trip level. A delay counter then runs for `TOUT_CYC` cycles, and reset is released when it finishes. A watchdog expiry arrives as a one-cycle request and shows up as reset in that same cycle. The delay starts when the request ends. Two sticky cause flags record which source fired, so that software can read them. Each flag is cleared by a one-cycle pulse on its own clear input.

Top module: `rst_sequencer`

## Requirements
- R1: While `rst` is high, `sys_rst` is 1 and both cause flags are 0. After `rst` goes low, `sys_rst` falls at the `TOUT_CYC`-th clock edge that samples `rst` low.
- R2: With `bod_en`=1, when `sup_low`=1 is sampled on `FILT_CYC` consecutive clock edges, `sys_rst` and `bod_flag` are 1 right after the last of those edges.
- R3: A dip in which `sup_low`=1 is sampled on only `FILT_CYC`-1 consecutive edges leaves `sys_rst` and `bod_flag` at 0.
- R4: After a brown-out, `sys_rst` stays 1 until an edge samples `sup_high`=1 with `sup_low`=0. It then falls at the `TOUT_CYC`-th edge after that sampling edge.
- R5: `sys_rst` is 1 in every cycle in which `wdt_req` is 1, including the request cycle itself.
- R6: After a one-cycle `wdt_req`, `sys_rst` falls at the `TOUT_CYC`-th edge after the edge that sampled the request. A new request during the delay restarts it from zero. `wdt_flag` is set at the edge that samples the request.
- R7: With `bod_en`=0, the supply flags have no effect: a dip of any length leaves `sys_rst` and `bod_flag` at 0.
- R8: If a qualified brown-out occurs while the delay is running, the delay is discarded. Reset is held until the next sampled rise, and a full `TOUT_CYC` delay follows that rise.
- R9: `bod_flag` (cause index 0) and `wdt_flag` (cause index 1) are sticky. Each is cleared only at the edge that samples its clear input at 1.
- R10: If a flag's source fires in the same cycle that its clear input is 1, the flag stays set.
- R11: Dropping `bod_en` while reset is held for a brown-out starts the delay as a rise would. `sys_rst` falls at the `TOUT_CYC`-th edge after the edge that samples `bod_en`=0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset; also starts the start-up delay |
| bod_en | input | 1 | Enables brown-out detection |
| sup_low | input | 1 | Supply is below the lower trip level |
| sup_high | input | 1 | Supply is above the upper trip level |
| wdt_req | input | 1 | One-cycle watchdog expiry request |
| clr_bod_flag | input | 1 | Write-one-to-clear for the brown-out cause flag |
| clr_wdt_flag | input | 1 | Write-one-to-clear for the watchdog cause flag |
| sys_rst | output | 1 | System reset, active high |
| bod_flag | output | 1 | Sticky brown-out cause flag |
| wdt_flag | output | 1 | Sticky watchdog cause flag |

## Verification
The bench builds the sequencer with `FILT_CYC`=5 and `TOUT_CYC`=16. With these values, a dip of exactly one cycle fewer than the filter length, and one of exactly the filter length, are both cheap to drive. The release edge can be checked one cycle before and at the exact expected edge. The short delay also leaves room to land a qualified dip inside a running delay, and a second watchdog request in the middle of the first delay, within a few dozen cycles each.

// File: rtl/rstseq_pkg.sv
package rstseq_pkg;

    localparam int SRC_BOD = 0;
    localparam int SRC_WDT = 1;
    localparam int N_SRC   = 2;

    typedef enum logic [1:0] {
        ST_RUN   = 2'd0,
        ST_DELAY = 2'd1,
        ST_BROWN = 2'd2
    } seq_state_e;

    typedef struct packed {
        logic wdt;
        logic bod;
    } rst_cause_t;

    // Next-state rule: a qualified brown-out beats everything else,
    // and a watchdog request re-arms the delay.
    function automatic seq_state_e seq_next(
        input seq_state_e cur,
        input logic       qual_dip,
        input logic       wdt,
        input logic       delay_done,
        input logic       det_en,
        input logic       rise_ok
    );
        seq_state_e nxt;
        nxt = cur;
        unique case (cur)
            ST_RUN: begin
                if (qual_dip)  nxt = ST_BROWN;
                else if (wdt)  nxt = ST_DELAY;
            end
            ST_DELAY: begin
                if (qual_dip)                nxt = ST_BROWN;
                else if (delay_done && !wdt) nxt = ST_RUN;
            end
            ST_BROWN: begin
                if (!det_en || rise_ok) nxt = ST_DELAY;
            end
            default: nxt = ST_DELAY;
        endcase
        return nxt;
    endfunction

endpackage

// File: rtl/rstseq_dip_filter.sv
module rstseq_dip_filter #(
    parameter int FILT_CYC = 8
) (
    input  logic clk,
    input  logic rst,
    input  logic det_en,
    input  logic below,
    output logic qual_dip
);
    localparam int CW = $clog2(FILT_CYC + 1);
    localparam logic [CW-1:0] LAST = CW'(FILT_CYC - 1);
    localparam logic [CW-1:0] SAT  = CW'(FILT_CYC);

    logic [CW-1:0] run_len;
    logic          low_seen;

    assign low_seen = det_en && below;

    always_ff @(posedge clk) begin
        if (rst || !low_seen) begin
            run_len <= '0;
        end else if (run_len != SAT) begin
            run_len <= run_len + 1'b1;
        end
    end

    // One pulse on the edge that samples the FILT_CYC-th low cycle
    assign qual_dip = low_seen && (run_len == LAST);

endmodule

// File: rtl/rstseq_delay_timer.sv
module rstseq_delay_timer #(
    parameter int TOUT_CYC = 64
) (
    input  logic clk,
    input  logic rst,
    input  logic restart,
    input  logic run,
    output logic done
);
    localparam int CW = $clog2(TOUT_CYC + 1);
    localparam logic [CW-1:0] LAST = CW'(TOUT_CYC - 1);

    logic [CW-1:0] ticks;

    always_ff @(posedge clk) begin
        if (rst || restart) begin
            ticks <= '0;
        end else if (run && ticks != LAST) begin
            ticks <= ticks + 1'b1;
        end
    end

    assign done = run && !restart && (ticks == LAST);

endmodule

// File: rtl/rstseq_cause_flags.sv
module rstseq_cause_flags #(
    parameter int N = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] set_i,
    input  logic [N-1:0] clr_i,
    output logic [N-1:0] flag_o
);
    generate
        for (genvar i = 0; i < N; i++) begin : g_flag
            always_ff @(posedge clk) begin
                if (rst) begin
                    flag_o[i] <= 1'b0;
                end else if (set_i[i]) begin
                    flag_o[i] <= 1'b1;
                end else if (clr_i[i]) begin
                    flag_o[i] <= 1'b0;
                end
            end
        end
    endgenerate

endmodule

// File: rtl/rst_sequencer.sv
module rst_sequencer #(
    parameter int FILT_CYC = 8,
    parameter int TOUT_CYC = 64
) (
    input  logic clk,
    input  logic rst,
    input  logic bod_en,
    input  logic sup_low,
    input  logic sup_high,
    input  logic wdt_req,
    input  logic clr_bod_flag,
    input  logic clr_wdt_flag,
    output logic sys_rst,
    output logic bod_flag,
    output logic wdt_flag
);
    import rstseq_pkg::*;

    seq_state_e state_q;
    seq_state_e state_d;
    logic       qual_dip;
    logic       delay_done;
    logic       delay_restart;
    logic       rise_ok;
    rst_cause_t cause_set;
    rst_cause_t cause_clr;
    rst_cause_t cause_q;

    rstseq_dip_filter #(.FILT_CYC(FILT_CYC)) u_filter (
        .clk      (clk),
        .rst      (rst),
        .det_en   (bod_en),
        .below    (sup_low),
        .qual_dip (qual_dip)
    );

    assign delay_restart = (state_q != ST_DELAY) || wdt_req;

    rstseq_delay_timer #(.TOUT_CYC(TOUT_CYC)) u_timer (
        .clk     (clk),
        .rst     (rst),
        .restart (delay_restart),
        .run     (state_q == ST_DELAY),
        .done    (delay_done)
    );

    assign rise_ok = sup_high && !sup_low;
    assign state_d = seq_next(state_q, qual_dip, wdt_req, delay_done, bod_en, rise_ok);

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_DELAY;
        end else begin
            state_q <= state_d;
        end
    end

    assign sys_rst = (state_q != ST_RUN) || wdt_req;

    assign cause_set.bod = qual_dip;
    assign cause_set.wdt = wdt_req;
    assign cause_clr.bod = clr_bod_flag;
    assign cause_clr.wdt = clr_wdt_flag;

    rstseq_cause_flags #(.N(N_SRC)) u_flags (
        .clk    (clk),
        .rst    (rst),
        .set_i  (cause_set),
        .clr_i  (cause_clr),
        .flag_o (cause_q)
    );

    assign bod_flag = cause_q.bod;
    assign wdt_flag = cause_q.wdt;

endmodule

// File: rtl/rst_sequencer_chk.sv
module rst_sequencer_chk (
    input logic                   clk,
    input logic                   rst,
    input logic                   bod_en,
    input logic                   sup_low,
    input logic                   wdt_req,
    input logic                   clr_bod_flag,
    input logic                   clr_wdt_flag,
    input logic                   sys_rst,
    input logic                   bod_flag,
    input logic                   wdt_flag,
    input rstseq_pkg::seq_state_e state_q
);
    import rstseq_pkg::*;

    assert_wdt_same_cycle_R5: assert property (@(posedge clk) disable iff (rst)
        wdt_req |-> sys_rst);

    assert_wdt_holds_R6: assert property (@(posedge clk) disable iff (rst)
        wdt_req |=> sys_rst);

    assert_brown_holds_R4: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_BROWN) |-> sys_rst);

    assert_bod_flag_cause_R2: assert property (@(posedge clk) disable iff (rst)
        $rose(bod_flag) |-> ($past(bod_en) && $past(sup_low) && sys_rst));

    assert_wdt_flag_cause_R6: assert property (@(posedge clk) disable iff (rst)
        $rose(wdt_flag) |-> $past(wdt_req));

    assert_bod_sticky_R9: assert property (@(posedge clk) disable iff (rst)
        $fell(bod_flag) |-> $past(clr_bod_flag));

    assert_wdt_sticky_R9: assert property (@(posedge clk) disable iff (rst)
        $fell(wdt_flag) |-> $past(clr_wdt_flag));

    assert_set_wins_R10: assert property (@(posedge clk) disable iff (rst)
        wdt_req |=> wdt_flag);

    assert_release_from_delay_R4: assert property (@(posedge clk) disable iff (rst)
        $fell(sys_rst) |-> ($past(state_q) == ST_DELAY && !$past(wdt_req)));

    assert_disabled_no_brown_R7: assert property (@(posedge clk) disable iff (rst)
        (!bod_en && state_q != ST_BROWN) |=> (state_q != ST_BROWN));

endmodule

bind rst_sequencer rst_sequencer_chk u_chk (
    .clk          (clk),
    .rst          (rst),
    .bod_en       (bod_en),
    .sup_low      (sup_low),
    .wdt_req      (wdt_req),
    .clr_bod_flag (clr_bod_flag),
    .clr_wdt_flag (clr_wdt_flag),
    .sys_rst      (sys_rst),
    .bod_flag     (bod_flag),
    .wdt_flag     (wdt_flag),
    .state_q      (state_q)
);

// File: tb/tb_rst_sequencer.sv
`timescale 1ns/1ps
module tb_rst_sequencer;
    localparam int FILT = 5;
    localparam int TOUT = 16;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic bod_en = 1'b1;
    logic sup_low = 1'b0;
    logic sup_high = 1'b1;
    logic wdt_req = 1'b0;
    logic clr_bod_flag = 1'b0;
    logic clr_wdt_flag = 1'b0;
    logic sys_rst, bod_flag, wdt_flag;

    int n_checks = 0;
    int n_errors = 0;
    bit finished = 1'b0;

    always #5 clk = ~clk;

    rst_sequencer #(.FILT_CYC(FILT), .TOUT_CYC(TOUT)) dut (
        .clk(clk), .rst(rst), .bod_en(bod_en), .sup_low(sup_low),
        .sup_high(sup_high), .wdt_req(wdt_req), .clr_bod_flag(clr_bod_flag),
        .clr_wdt_flag(clr_wdt_flag), .sys_rst(sys_rst), .bod_flag(bod_flag),
        .wdt_flag(wdt_flag)
    );

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input string tag, input logic act, input logic exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s: actual=%b expected=%b", tag, act, exp);
        end
    endtask

    task automatic go_low();
        sup_low = 1'b1; sup_high = 1'b0;
    endtask

    task automatic go_high();
        sup_low = 1'b0; sup_high = 1'b1;
    endtask

    task automatic pulse_wdt();
        wdt_req = 1'b1;
        step(1);
        wdt_req = 1'b0;
    endtask

    // check release lands on the TOUT-th edge after the zero edge just passed
    task automatic expect_release(input string tag);
        step(TOUT - 1);
        chk({tag, " held one edge before release"}, sys_rst, 1'b1);
        step(1);
        chk({tag, " released at expected edge"}, sys_rst, 1'b0);
    endtask

    task automatic t_reset();
        step(3);
        chk("R1 sys_rst during rst", sys_rst, 1'b1);
        chk("R1 bod_flag during rst", bod_flag, 1'b0);
        chk("R1 wdt_flag during rst", wdt_flag, 1'b0);
        rst = 1'b0;
        step(TOUT - 1);
        chk("R1 held before start-up delay ends", sys_rst, 1'b1);
        step(1);
        chk("R1 released after start-up delay", sys_rst, 1'b0);
    endtask

    task automatic t_short_glitch();
        go_low();
        for (int i = 0; i < FILT - 1; i++) begin
            step(1);
            chk("R3 glitch keeps sys_rst low", sys_rst, 1'b0);
        end
        go_high();
        step(3);
        chk("R3 glitch leaves sys_rst low", sys_rst, 1'b0);
        chk("R3 glitch leaves bod_flag clear", bod_flag, 1'b0);
    endtask

    task automatic t_brownout();
        go_low();
        step(FILT - 1);
        chk("R2 no reset before filter length", sys_rst, 1'b0);
        step(1);
        chk("R2 reset at filter length", sys_rst, 1'b1);
        chk("R2 bod_flag set", bod_flag, 1'b1);
        step(3 * TOUT);
        chk("R4 held while supply low", sys_rst, 1'b1);
        sup_low = 1'b0;
        step(5);
        chk("R4 held inside hysteresis band", sys_rst, 1'b1);
        sup_high = 1'b1;
        step(1);
        chk("R4 held at rise edge", sys_rst, 1'b1);
        expect_release("R4");
        chk("R9 bod_flag sticky after release", bod_flag, 1'b1);
        clr_bod_flag = 1'b1;
        step(1);
        clr_bod_flag = 1'b0;
        chk("R9 bod_flag cleared by write-one", bod_flag, 1'b0);
    endtask

    task automatic t_watchdog();
        wdt_req = 1'b1;
        #1;
        chk("R5 reset in request cycle", sys_rst, 1'b1);
        step(1);
        wdt_req = 1'b0;
        chk("R6 wdt_flag set", wdt_flag, 1'b1);
        expect_release("R6");
        pulse_wdt();
        step(TOUT / 2);
        pulse_wdt();
        expect_release("R6 restart");
    endtask

    task automatic t_set_over_clear();
        clr_wdt_flag = 1'b1;
        wdt_req = 1'b1;
        step(1);
        wdt_req = 1'b0;
        clr_wdt_flag = 1'b0;
        chk("R10 set wins over clear", wdt_flag, 1'b1);
        step(TOUT);
        chk("R10 delay from request completes", sys_rst, 1'b0);
        clr_wdt_flag = 1'b1;
        step(1);
        clr_wdt_flag = 1'b0;
        chk("R9 wdt_flag cleared by write-one", wdt_flag, 1'b0);
        step(2);
        chk("R9 wdt_flag stays clear", wdt_flag, 1'b0);
    endtask

    task automatic t_dip_in_delay();
        pulse_wdt();
        step(3);
        go_low();
        step(FILT);
        chk("R8 dip in delay keeps reset", sys_rst, 1'b1);
        chk("R8 dip in delay sets bod_flag", bod_flag, 1'b1);
        step(2 * TOUT);
        chk("R8 delay discarded while low", sys_rst, 1'b1);
        go_high();
        step(1);
        expect_release("R8");
        clr_bod_flag = 1'b1;
        clr_wdt_flag = 1'b1;
        step(1);
        clr_bod_flag = 1'b0;
        clr_wdt_flag = 1'b0;
    endtask

    task automatic t_disabled();
        bod_en = 1'b0;
        go_low();
        step(3 * FILT);
        chk("R7 disabled dip leaves sys_rst low", sys_rst, 1'b0);
        chk("R7 disabled dip leaves bod_flag clear", bod_flag, 1'b0);
        go_high();
        step(1);
        bod_en = 1'b1;
        step(2);
        chk("R7 re-enable with good supply", sys_rst, 1'b0);
    endtask

    task automatic t_disable_in_hold();
        go_low();
        step(FILT);
        chk("R11 brown-out entered", sys_rst, 1'b1);
        step(4);
        bod_en = 1'b0;
        step(1);
        expect_release("R11");
        go_high();
        step(1);
        bod_en = 1'b1;
        step(2);
        chk("R11 stays running after re-enable", sys_rst, 1'b0);
    endtask

    initial begin
        t_reset();
        t_short_glitch();
        t_brownout();
        t_watchdog();
        t_set_over_clear();
        t_dip_in_delay();
        t_disabled();
        t_disable_in_hold();
        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_checks++;
            n_errors++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    end

endmodule